// File: doc/BRIEF.md
# Replicated Write Quorum Voter

This block sits between a group of replicas and a critical write target. Each replica sends its proposed write (address, data and a length field) tagged with its own replica number. Every replica owns exactly one proposal slot. A new proposal is compared with every proposal already held, and the write is released downstream as soon as `f+1` slots hold identical content. A fault among the replicas is masked at once, without waiting for the slower ones.

If any two proposals in a round differ, the voter suspends. The stored proposals are then frozen, and software reads them out through a diagnosis port. The progress sequence number stops moving. Replicas that have not yet proposed may still fill their empty slots, and a quorum reached later still releases the write. Voting resumes only after `f+1` distinct replicas vote for a reset. The reset empties every slot, clears the vote tally and advances the sequence number. The fault threshold `f` is taken while reset is asserted. With it, `2f+1` replicas are active, numbered from 0 upward.

Top module: `quorum_voter`

## Requirements
- R1: The threshold `cfg_f` is captured while `rst` is high and held until the next reset. Changing `cfg_f` afterwards has no effect. The number of active replicas is `2f+1` and the quorum is `f+1`.
- R2: A proposal whose replica number is `2f+1` or higher is refused: `prop_refused` pulses in the cycle after it, and no slot changes.
- R3: A proposal aimed at a slot that is already occupied is refused and leaves the slot unchanged. This covers a second proposal from the same replica in a round and any overwrite while suspended.
- R4: `apply_valid` pulses for one cycle, in the cycle after the accepted proposal that brings the number of identical slots (address, data and length all equal) to `f+1`. It carries that operation and fires at most once per round.
- R5: An accepted proposal that differs from any occupied slot sets `suspended` in the following cycle.
- R6: When every active slot is full and no disagreement has occurred, the round closes: `seq` increases by one and all slots empty in the same cycle that `apply` or the last accept becomes visible.
- R7: While suspended, occupied slots keep their content and `seq` does not advance. Empty slots still accept proposals, and a quorum reached there still produces `apply_valid`.
- R8: Each reset vote sets the bit of its replica, and votes from replica numbers `2f+1` or higher are ignored. When `f+1` bits are set, the next cycle shows all slots empty, `suspended` low and `seq` one higher. A proposal in that same cycle is refused.
- R9: `diag_sel` selects a slot; `diag_full`, `diag_addr`, `diag_data` and `diag_len` show its state combinationally.
- R10: After reset, `seq` is 0, `suspended` is low, no pulse is active and all slots are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `cfg_f` |
| cfg_f | input | FW | Fault threshold f (0..FMAX) |
| prop_valid | input | 1 | Proposal strobe |
| prop_id | input | IDW | Replica number of the proposer |
| prop_addr | input | AW | Proposed write address |
| prop_data | input | DW | Proposed write data |
| prop_len | input | LW | Proposed length field |
| rst_vote_valid | input | 1 | Reset vote strobe |
| rst_vote_id | input | IDW | Replica number casting the reset vote |
| prop_refused | output | 1 | Pulse: the previous cycle's proposal was refused |
| apply_valid | output | 1 | Pulse: agreed write released |
| apply_addr | output | AW | Agreed address |
| apply_data | output | DW | Agreed data |
| apply_len | output | LW | Agreed length |
| suspended | output | 1 | Voting suspended after disagreement |
| seq | output | SW | Progress sequence number |
| diag_sel | input | IDW | Slot selected for diagnosis |
| diag_full | output | 1 | Selected slot is occupied |
| diag_addr | output | AW | Selected slot address |
| diag_data | output | DW | Selected slot data |
| diag_len | output | LW | Selected slot length |

## Verification
The assertions check the following on every cycle:
- `seq` only ever moves by one step.
- `seq` and every occupied slot stay frozen while suspended.
- Suspension only starts after an accepted proposal that disagrees.
- An apply pulse is always preceded by an accept that reaches a quorum.
- The reset tally empties after it fires.

Only the bench scenarios can show the following, because each depends on the threshold and on arrival order:
- The apply pulse lands exactly on the `(f+1)`-th matching arrival.
- A late quorum is still released during suspension.
- Out-of-range and duplicate proposals leave no trace.
- Exactly `f+1` reset votes are needed.

// File: rtl/qv_pkg.sv
package qv_pkg;
    parameter int FMAX = 3;
    parameter int AW   = 8;
    parameter int DW   = 16;
    parameter int LW   = 2;
    parameter int SW   = 8;

    localparam int NMAX = 2 * FMAX + 1;
    localparam int IDW  = (NMAX > 1) ? $clog2(NMAX) : 1;
    localparam int FW   = (FMAX > 0) ? $clog2(FMAX + 1) : 1;
    localparam int CW   = $clog2(NMAX + 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [LW-1:0] len;
    } op_t;

    function automatic logic [NMAX-1:0] active_mask(input logic [FW-1:0] f);
        logic [NMAX-1:0] m;
        for (int i = 0; i < NMAX; i++)
            m[i] = (i < 2 * int'(f) + 1);
        return m;
    endfunction

    function automatic logic [CW-1:0] popcnt(input logic [NMAX-1:0] v);
        logic [CW-1:0] c;
        c = '0;
        for (int i = 0; i < NMAX; i++)
            c = c + CW'(v[i]);
        return c;
    endfunction
endpackage

// File: rtl/qv_slot_bank.sv
module qv_slot_bank
    import qv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDW-1:0]  wr_id,
    input  op_t             wr_op,
    input  logic            clr,
    input  logic            freeze,
    input  logic [IDW-1:0]  rd_sel,
    output logic [NMAX-1:0] full,
    output logic [NMAX-1:0] same,
    output logic            rd_full,
    output op_t             rd_op
);
    op_t slot_q [NMAX];

    genvar g;
    generate
        for (g = 0; g < NMAX; g++) begin : gslot
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    full[g] <= 1'b0;
                end else if (wr_en && wr_id == IDW'(g)) begin
                    full[g] <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[g] <= '0;
                end else if (!clr && wr_en && wr_id == IDW'(g)) begin
                    slot_q[g] <= wr_op;
                end
            end

            assign same[g] = full[g] && (slot_q[g] == wr_op);

            // R7: an occupied slot never changes while frozen unless cleared
            a_r7_slot_frozen: assert property (@(posedge clk) disable iff (rst)
                ($past(full[g]) && $past(freeze) && !$past(clr)) |-> $stable(slot_q[g]));
        end
    endgenerate

    always_comb begin
        rd_full = 1'b0;
        rd_op   = '0;
        for (int i = 0; i < NMAX; i++) begin
            if (rd_sel == IDW'(i)) begin
                rd_full = full[i];
                rd_op   = slot_q[i];
            end
        end
    end
endmodule

// File: rtl/qv_reset_tally.sv
module qv_reset_tally
    import qv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            vote_valid,
    input  logic [IDW-1:0]  vote_id,
    input  logic [NMAX-1:0] act_mask,
    input  logic [CW-1:0]   quorum,
    output logic            fire
);
    logic [NMAX-1:0] vec_q;
    logic [NMAX-1:0] vec_nx;

    always_comb begin
        vec_nx = vec_q;
        for (int i = 0; i < NMAX; i++) begin
            if (vote_valid && vote_id == IDW'(i) && act_mask[i])
                vec_nx[i] = 1'b1;
        end
        fire = (popcnt(vec_nx) >= quorum);
    end

    always_ff @(posedge clk) begin
        if (rst || fire) vec_q <= '0;
        else             vec_q <= vec_nx;
    end

    // R8: the tally is empty after it has fired
    a_r8_tally_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(fire) |-> (vec_q == '0));

    // R8: votes never set bits outside the active replicas
    a_r8_inactive_ignored: assert property (@(posedge clk) disable iff (rst)
        ((vec_q & ~act_mask) == '0));
endmodule

// File: rtl/quorum_voter.sv
module quorum_voter
    import qv_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [FW-1:0]  cfg_f,
    input  logic           prop_valid,
    input  logic [IDW-1:0] prop_id,
    input  logic [AW-1:0]  prop_addr,
    input  logic [DW-1:0]  prop_data,
    input  logic [LW-1:0]  prop_len,
    input  logic           rst_vote_valid,
    input  logic [IDW-1:0] rst_vote_id,
    output logic           prop_refused,
    output logic           apply_valid,
    output logic [AW-1:0]  apply_addr,
    output logic [DW-1:0]  apply_data,
    output logic [LW-1:0]  apply_len,
    output logic           suspended,
    output logic [SW-1:0]  seq,
    input  logic [IDW-1:0] diag_sel,
    output logic           diag_full,
    output logic [AW-1:0]  diag_addr,
    output logic [DW-1:0]  diag_data,
    output logic [LW-1:0]  diag_len
);
    logic [FW-1:0]   f_q;
    logic [NMAX-1:0] act_mask;
    logic [CW-1:0]   quorum;
    logic [NMAX-1:0] full, same, id_hot, full_after;
    logic            id_ok, accept, mismatch, round_done, apply_fire, clr, rst_fire;
    logic [CW-1:0]   match_cnt;
    logic            applied_q, susp_q;
    logic [SW-1:0]   seq_q;
    op_t             new_op, apply_q, diag_op;

    assign new_op = '{addr: prop_addr, data: prop_data, len: prop_len};

    always_ff @(posedge clk) begin
        if (rst) f_q <= (int'(cfg_f) > FMAX) ? FW'(FMAX) : cfg_f;
    end

    assign act_mask = active_mask(f_q);
    assign quorum   = CW'(f_q) + CW'(1);

    qv_slot_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(accept), .wr_id(prop_id), .wr_op(new_op),
        .clr(clr), .freeze(susp_q), .rd_sel(diag_sel),
        .full(full), .same(same), .rd_full(diag_full), .rd_op(diag_op)
    );

    qv_reset_tally u_tally (
        .clk(clk), .rst(rst), .vote_valid(rst_vote_valid), .vote_id(rst_vote_id),
        .act_mask(act_mask), .quorum(quorum), .fire(rst_fire)
    );

    always_comb begin
        id_hot = '0;
        for (int i = 0; i < NMAX; i++)
            id_hot[i] = (prop_id == IDW'(i));
        id_ok      = |(id_hot & act_mask);
        accept     = prop_valid && id_ok && !(|(id_hot & full)) && !rst_fire;
        mismatch   = |(full & ~same & act_mask);
        match_cnt  = popcnt(same) + CW'(1);
        full_after = full | id_hot;
        apply_fire = accept && !applied_q && (match_cnt >= quorum);
        round_done = accept && !susp_q && !mismatch
                     && ((full_after & act_mask) == act_mask);
        clr        = rst_fire || round_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            applied_q    <= 1'b0;
            susp_q       <= 1'b0;
            seq_q        <= '0;
            apply_valid  <= 1'b0;
            apply_q      <= '0;
            prop_refused <= 1'b0;
        end else begin
            prop_refused <= prop_valid && !accept;
            apply_valid  <= apply_fire;
            if (apply_fire) apply_q <= new_op;
            applied_q    <= clr ? 1'b0 : (applied_q | apply_fire);
            susp_q       <= rst_fire ? 1'b0 : (susp_q | (accept && mismatch));
            if (clr) seq_q <= seq_q + SW'(1);
        end
    end

    assign suspended  = susp_q;
    assign seq        = seq_q;
    assign apply_addr = apply_q.addr;
    assign apply_data = apply_q.data;
    assign apply_len  = apply_q.len;
    assign diag_addr  = diag_op.addr;
    assign diag_data  = diag_op.data;
    assign diag_len   = diag_op.len;

    // R6: the sequence number only ever steps by one
    a_r6_seq_step: assert property (@(posedge clk) disable iff (rst)
        (seq_q != $past(seq_q)) |-> (seq_q == $past(seq_q) + SW'(1)));

    // R7: while suspended and no reset quorum, the sequence number holds
    a_r7_seq_frozen: assert property (@(posedge clk) disable iff (rst)
        ($past(susp_q) && !$past(rst_fire)) |-> $stable(seq_q));

    // R5: suspension only starts after an accepted disagreeing proposal
    a_r5_suspend_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(susp_q) |-> $past(accept && mismatch));

    // R4: a release is always backed by a quorum of identical slots
    a_r4_apply_quorum: assert property (@(posedge clk) disable iff (rst)
        apply_valid |-> $past(accept && match_cnt >= quorum));

    // R4: at most one release per round
    a_r4_once_per_round: assert property (@(posedge clk) disable iff (rst)
        (applied_q && !clr) |-> !apply_fire);
endmodule

// File: tb/quorum_voter_test.sv
module quorum_voter_test;
    import qv_pkg::*;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [FW-1:0]  cfg_f = '0;
    logic           prop_valid = 1'b0;
    logic [IDW-1:0] prop_id = '0;
    logic [AW-1:0]  prop_addr = '0;
    logic [DW-1:0]  prop_data = '0;
    logic [LW-1:0]  prop_len = '0;
    logic           rst_vote_valid = 1'b0;
    logic [IDW-1:0] rst_vote_id = '0;
    logic [IDW-1:0] diag_sel = '0;
    logic           prop_refused, apply_valid, suspended, diag_full;
    logic [AW-1:0]  apply_addr, diag_addr;
    logic [DW-1:0]  apply_data, diag_data;
    logic [LW-1:0]  apply_len, diag_len;
    logic [SW-1:0]  seq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    quorum_voter uut (
        .clk(clk), .rst(rst), .cfg_f(cfg_f),
        .prop_valid(prop_valid), .prop_id(prop_id), .prop_addr(prop_addr),
        .prop_data(prop_data), .prop_len(prop_len),
        .rst_vote_valid(rst_vote_valid), .rst_vote_id(rst_vote_id),
        .prop_refused(prop_refused), .apply_valid(apply_valid),
        .apply_addr(apply_addr), .apply_data(apply_data), .apply_len(apply_len),
        .suspended(suspended), .seq(seq), .diag_sel(diag_sel),
        .diag_full(diag_full), .diag_addr(diag_addr), .diag_data(diag_data),
        .diag_len(diag_len)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int f);
        @(negedge clk);
        rst = 1'b1;
        cfg_f = FW'(f);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cfg_f = ~FW'(f);   // R1: later changes must not matter
        diag_sel = '0;
        @(negedge clk);
    endtask

    // Drive one proposal for a cycle and sample the registered responses.
    task automatic propose(input int id, input int a, input int d, input int l,
                           output bit ap, output bit rf);
        prop_valid = 1'b1;
        prop_id = IDW'(id);
        prop_addr = AW'(a);
        prop_data = DW'(d);
        prop_len = LW'(l);
        @(negedge clk);
        prop_valid = 1'b0;
        ap = apply_valid;
        rf = prop_refused;
    endtask

    task automatic vote(input int id);
        rst_vote_valid = 1'b1;
        rst_vote_id = IDW'(id);
        @(negedge clk);
        rst_vote_valid = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ap, rf;
        int n, exp_seq, ga, gd, bd;
        for (int f = 0; f <= FMAX; f++) begin
            n = 2 * f + 1;
            ga = 16 + f;
            gd = 16'hA000 + f;
            bd = 16'h5000 + f;
            exp_seq = 0;
            do_reset(f);
            // R10 reset state
            chk(seq == 0, "R10 seq", int'(seq), 0);
            chk(suspended == 0, "R10 suspended", int'(suspended), 0);
            chk(apply_valid == 0, "R10 apply", int'(apply_valid), 0);
            chk(diag_full == 0, "R10 slot empty", int'(diag_full), 0);

            // Agreeing round, with a duplicate from replica 0
            for (int k = 0; k < n; k++) begin
                propose(k, ga, gd, 2, ap, rf);
                chk(rf == 0, "R3 accept fresh", int'(rf), 0);
                chk(ap == (k == f), "R1 R4 apply position", int'(ap), int'(k == f));
                if (ap) begin
                    chk(apply_addr == AW'(ga), "R4 apply addr", int'(apply_addr), ga);
                    chk(apply_data == DW'(gd), "R4 apply data", int'(apply_data), gd);
                    chk(apply_len == 2, "R4 apply len", int'(apply_len), 2);
                end
                if (k == 0 && f >= 1) begin
                    propose(0, ga, bd, 2, ap, rf);
                    chk(rf == 1, "R3 duplicate refused", int'(rf), 1);
                    chk(ap == 0, "R3 duplicate no apply", int'(ap), 0);
                    diag_sel = '0;
                    #1;
                    chk(diag_data == DW'(gd), "R3 R9 slot kept", int'(diag_data), gd);
                    chk(suspended == 0, "R3 no suspend", int'(suspended), 0);
                end
            end
            exp_seq++;
            chk(int'(seq) == exp_seq, "R6 seq advanced", int'(seq), exp_seq);
            diag_sel = '0;
            #1;
            chk(diag_full == 0, "R6 slots cleared", int'(diag_full), 0);

            // Out-of-range replica number
            if (n < NMAX) begin
                propose(n, ga, gd, 1, ap, rf);
                chk(rf == 1, "R2 out of range refused", int'(rf), 1);
                diag_sel = IDW'(n);
                #1;
                chk(diag_full == 0, "R2 slot untouched", int'(diag_full), 0);
                chk(int'(seq) == exp_seq, "R2 seq unchanged", int'(seq), exp_seq);
            end

            // Disagreeing round: replica 0 is faulty
            if (f >= 1) begin
                propose(0, ga, bd, 2, ap, rf);
                chk(ap == 0, "R4 single no apply", int'(ap), 0);
                for (int k = 1; k < n; k++) begin
                    propose(k, ga, gd, 2, ap, rf);
                    chk(rf == 0, "R7 empty slot accepted", int'(rf), 0);
                    chk(ap == (k == f + 1), "R7 late quorum apply", int'(ap), int'(k == f + 1));
                    if (ap) chk(apply_data == DW'(gd), "R7 apply data", int'(apply_data), gd);
                    if (k == 1) chk(suspended == 1, "R5 suspended", int'(suspended), 1);
                end
                chk(int'(seq) == exp_seq, "R7 seq frozen", int'(seq), exp_seq);
                propose(1, ga, bd, 2, ap, rf);
                chk(rf == 1, "R3 overwrite refused", int'(rf), 1);
                diag_sel = '0;
                #1;
                chk(diag_full == 1 && diag_data == DW'(bd), "R7 R9 frozen slot", int'(diag_data), bd);
                diag_sel = 1;
                #1;
                chk(diag_data == DW'(gd), "R7 R9 frozen good slot", int'(diag_data), gd);
            end

            // Reset votes
            if (n < NMAX) begin
                vote(n);
                chk(int'(seq) == exp_seq, "R8 inactive vote ignored", int'(seq), exp_seq);
            end
            for (int j = 0; j <= f; j++) begin
                vote(j);
                if (j < f) begin
                    chk(int'(seq) == exp_seq, "R8 below quorum", int'(seq), exp_seq);
                    if (f >= 1) chk(suspended == 1, "R8 still suspended", int'(suspended), 1);
                end
            end
            exp_seq++;
            chk(int'(seq) == exp_seq, "R8 seq after reset", int'(seq), exp_seq);
            chk(suspended == 0, "R8 resumed", int'(suspended), 0);
            diag_sel = '0;
            #1;
            chk(diag_full == 0, "R8 slots emptied", int'(diag_full), 0);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule